// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Non-Blocking Data Cache

The block keeps a small file of registers, each describing one cache line that has missed and is waiting on main memory. The core presents every load miss with the line address it needs and the destination register to fill. The block compares the address with every open entry at once. The first miss to a line is a primary miss: it takes a free entry and sends one line request to memory. Any later miss to a line that is still waiting is a secondary miss: it joins the open entry, adds its destination register to that entry's list, and sends no memory request. The core is held back only when a miss cannot be recorded. For a primary miss this happens when every entry is in use. For a secondary miss it happens when the entry's destination list is full.

Memory reports a finished line fill by giving its line address. The matching entry is marked as filled. A single wake-up engine then replays that entry's destination registers, one per cycle, in the order the misses arrived. After the last one it frees the entry. When several entries are filled, they are replayed one entry at a time. A memory fill takes roughly 143 cycles, against 3 cycles for a cache hit. This lets many loads overlap with each other and with independent work.

Top module: `mshr_file`

## Requirements
- R1: A miss whose line has no open entry, while some entry is free, raises `mem_req_valid` in the same cycle with `mem_req_line` equal to the miss line, and does not stall. Entries are taken lowest free index first.
- R2: A miss to a line that already has an open entry with fewer than 4 recorded destinations neither stalls nor raises `mem_req_valid`. Its destination is appended to that entry.
- R3: A miss needing a new entry when all 8 entries are in use raises `stall` in the same cycle and raises no memory request. The miss is not recorded.
- R4: A miss to an open entry that already holds 4 destinations raises `stall` and is not recorded.
- R5: A fill presented on `refill_valid`/`refill_line` on clock edge k makes the matching entry's destinations appear on `wake_dest`, one per cycle, in arrival order. The first one is visible in the cycle after edge k+1. `wake_line` carries the line, and `wake_last` marks the final destination.
- R6: After its final wake-up the entry is free again, so a new miss to the same line is primary and the free count is restored.
- R7: A fill whose line has no open entry produces no wake-up and leaves open entries unchanged.
- R8: A miss and a fill to the same open line in the same cycle merge. The new destination is woken as the last one of that line's burst.
- R9: While reset is applied and just after it, `stall`, `mem_req_valid` and `wake_valid` are low.
- R10: Filled entries are replayed one at a time, lowest entry index first, with one idle cycle after each `wake_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid | input | 1 | A load miss is presented this cycle |
| miss_line | input | LINE_W | Line address of the miss |
| miss_dest | input | DEST_W | Destination register of the missing load |
| stall | output | 1 | Miss cannot be recorded; core must hold it |
| mem_req_valid | output | 1 | Line request to memory for a primary miss |
| mem_req_line | output | LINE_W | Line address of the memory request |
| refill_valid | input | 1 | Memory finished a line fill |
| refill_line | input | LINE_W | Line address of the finished fill |
| wake_valid | output | 1 | A destination register is released this cycle |
| wake_dest | output | DEST_W | Destination register to wake |
| wake_line | output | LINE_W | Line the woken load was waiting on |
| wake_last | output | 1 | Final destination of the current entry |

## Verification
Recording a new miss and closing an entry on a fill can both act on the same line in one cycle. This is the case where a merge could be lost or could arrive too late. The bench drives a secondary miss and the fill for that line on the same clock edge. It then expects the merged destination as the final wake-up of the burst, after the earlier ones. A second collision occurs when one entry is freed and the full file is probed on the following cycle. The bench checks that the ninth line stalls before the free and is accepted as primary after it.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_LINE_W  = 26;
  localparam int unsigned DEF_DEST_W  = 5;
  localparam int unsigned DEF_SLOTS   = 4;

  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_RUN  = 1'b1
  } drain_st_e;
endpackage

// File: rtl/mshr_lookup.sv
// Parallel compare of a key line address against all open entries.
module mshr_lookup #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = 26,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]         open_vec,
  input  logic [N-1:0][LW-1:0] line_vec,
  input  logic [LW-1:0]        key,
  output logic                 any_hit,
  output logic [IW-1:0]        hit_idx
);
  logic [N-1:0] hit_vec;

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = open_vec[g] && (line_vec[g] == key);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/mshr_pick.sv
// Lowest-index-first selector over a request vector.
module mshr_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign found = |req;
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = DEF_ENTRIES,
  parameter int unsigned LINE_W      = DEF_LINE_W,
  parameter int unsigned DEST_W      = DEF_DEST_W,
  parameter int unsigned NUM_SLOTS   = DEF_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [DEST_W-1:0] miss_dest,
  output logic              stall,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_line,
  input  logic              refill_valid,
  input  logic [LINE_W-1:0] refill_line,
  output logic              wake_valid,
  output logic [DEST_W-1:0] wake_dest,
  output logic [LINE_W-1:0] wake_line,
  output logic              wake_last
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int unsigned POS_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1_q  <= 1'b1;
      rst_int_n <= rst_s1_q;
    end
  end

  // entry state
  logic [NUM_ENTRIES-1:0]                          valid_q, valid_d;
  logic [NUM_ENTRIES-1:0]                          filled_q, filled_d;
  logic [NUM_ENTRIES-1:0][CNT_W-1:0]               cnt_q, cnt_d;
  logic [NUM_ENTRIES-1:0][LINE_W-1:0]              line_q, line_d;
  logic [NUM_ENTRIES-1:0][NUM_SLOTS-1:0][DEST_W-1:0] dest_q, dest_d;
  drain_st_e                                       st_q, st_d;
  logic [IDX_W-1:0]                                didx_q, didx_d;
  logic [POS_W-1:0]                                pos_q, pos_d;

  logic [NUM_ENTRIES-1:0] open_vec;
  logic                   miss_hit, fill_hit, free_found, rdy_found;
  logic [IDX_W-1:0]       miss_idx, fill_idx, free_idx, rdy_idx;
  logic                   accept, prim, sec, data_we;

  assign open_vec = valid_q & ~filled_q;

  mshr_lookup #(.N(NUM_ENTRIES), .LW(LINE_W), .IW(IDX_W)) u_miss_lu (
    .open_vec(open_vec), .line_vec(line_q), .key(miss_line),
    .any_hit(miss_hit), .hit_idx(miss_idx));

  mshr_lookup #(.N(NUM_ENTRIES), .LW(LINE_W), .IW(IDX_W)) u_fill_lu (
    .open_vec(open_vec), .line_vec(line_q), .key(refill_line),
    .any_hit(fill_hit), .hit_idx(fill_idx));

  mshr_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_free_pick (
    .req(~valid_q), .found(free_found), .idx(free_idx));

  mshr_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_rdy_pick (
    .req(valid_q & filled_q), .found(rdy_found), .idx(rdy_idx));

  // miss classification
  always_comb begin
    if (!miss_valid)   stall = 1'b0;
    else if (miss_hit) stall = (cnt_q[miss_idx] == CNT_W'(NUM_SLOTS));
    else               stall = !free_found;
  end

  assign accept        = miss_valid && !stall;
  assign prim          = accept && !miss_hit;
  assign sec           = accept && miss_hit;
  assign data_we       = prim || sec;
  assign mem_req_valid = prim;
  assign mem_req_line  = miss_line;

  // wake-up outputs
  assign wake_valid = (st_q == DR_RUN);
  assign wake_dest  = dest_q[didx_q][pos_q];
  assign wake_line  = line_q[didx_q];
  assign wake_last  = wake_valid &&
                      ((CNT_W'(pos_q) + CNT_W'(1)) == cnt_q[didx_q]);

  // next state
  always_comb begin
    valid_d  = valid_q;
    filled_d = filled_q;
    cnt_d    = cnt_q;
    line_d   = line_q;
    dest_d   = dest_q;
    st_d     = st_q;
    didx_d   = didx_q;
    pos_d    = pos_q;

    if (prim) begin
      valid_d[free_idx]     = 1'b1;
      filled_d[free_idx]    = 1'b0;
      cnt_d[free_idx]       = CNT_W'(1);
      line_d[free_idx]      = miss_line;
      dest_d[free_idx][0]   = miss_dest;
    end
    if (sec) begin
      dest_d[miss_idx][cnt_q[miss_idx][POS_W-1:0]] = miss_dest;
      cnt_d[miss_idx] = cnt_q[miss_idx] + CNT_W'(1);
    end
    if (refill_valid && fill_hit) filled_d[fill_idx] = 1'b1;

    unique case (st_q)
      DR_IDLE: begin
        if (rdy_found) begin
          st_d   = DR_RUN;
          didx_d = rdy_idx;
          pos_d  = '0;
        end
      end
      DR_RUN: begin
        if (wake_last) begin
          st_d             = DR_IDLE;
          valid_d[didx_q]  = 1'b0;
          filled_d[didx_q] = 1'b0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      default: st_d = DR_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q  <= '0;
      filled_q <= '0;
      cnt_q    <= '0;
      st_q     <= DR_IDLE;
      didx_q   <= '0;
      pos_q    <= '0;
    end else begin
      valid_q  <= valid_d;
      filled_q <= filled_d;
      cnt_q    <= cnt_d;
      st_q     <= st_d;
      didx_q   <= didx_d;
      pos_q    <= pos_d;
    end
  end

  // payload registers, written only when a miss is recorded
  always_ff @(posedge clk) begin
    if (data_we) begin
      line_q <= line_d;
      dest_q <= dest_d;
    end
  end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int unsigned LINE_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              stall,
  input logic              mem_req_valid,
  input logic [LINE_W-1:0] mem_req_line,
  input logic              wake_valid,
  input logic              wake_last,
  input logic [LINE_W-1:0] wake_line
);
  // R3: a stalled miss never reaches memory
  a_r3_no_req_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !mem_req_valid);

  // R3, R4: stall only answers a presented miss
  a_r4_stall_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> miss_valid);

  // R2: a line just requested is open next cycle, so it is not requested again
  a_r2_no_repeat_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !(mem_req_valid && mem_req_line == $past(mem_req_line)));

  // R5: a burst continues without gaps on the same line until its last
  a_r5_burst_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && !wake_last) |=> (wake_valid && wake_line == $past(wake_line)));

  // R10: one idle cycle after every final wake-up
  a_r10_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    wake_last |=> !wake_valid);
endmodule

bind mshr_file mshr_file_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .stall(stall),
  .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
  .wake_valid(wake_valid), .wake_last(wake_last), .wake_line(wake_line));

// File: tb/mshr_file_tb_top.sv
`timescale 1ns/1ps
module mshr_file_tb_top;
  localparam int unsigned LW = 26;
  localparam int unsigned DW = 5;
  localparam int unsigned MEM_LAT = 143;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_valid, refill_valid;
  logic [LW-1:0] miss_line, refill_line;
  logic [DW-1:0] miss_dest;
  logic          stall, mem_req_valid, wake_valid, wake_last;
  logic [LW-1:0] mem_req_line, wake_line;
  logic [DW-1:0] wake_dest;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mshr_file dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_dest(miss_dest), .stall(stall), .mem_req_valid(mem_req_valid),
    .mem_req_line(mem_req_line), .refill_valid(refill_valid),
    .refill_line(refill_line), .wake_valid(wake_valid), .wake_dest(wake_dest),
    .wake_line(wake_line), .wake_last(wake_last));

  task automatic chk(input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic do_miss(input logic [LW-1:0] line, input logic [DW-1:0] dest,
                         input bit exp_stall, input bit exp_req, input string rq);
    miss_valid = 1'b1; miss_line = line; miss_dest = dest;
    #1;
    chk(rq, "stall", stall, exp_stall);
    chk(rq, "mem_req_valid", mem_req_valid, exp_req);
    if (exp_req) chk(rq, "mem_req_line", mem_req_line, line);
    @(posedge clk); #1 miss_valid = 1'b0;
    @(negedge clk);
  endtask

  // Called just after the fill edge; checks the burst, then one settle cycle.
  task automatic wait_wakes(input logic [LW-1:0] line, input logic [DW-1:0] d [4],
                            input int n, input string rq);
    @(negedge clk);
    chk(rq, "wake_valid before start", wake_valid, 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(rq, "wake_valid", wake_valid, 1);
      chk(rq, "wake_dest", wake_dest, d[i]);
      chk(rq, "wake_line", wake_line, line);
      chk(rq, "wake_last", wake_last, (i == n - 1));
    end
    @(negedge clk);
  endtask

  task automatic refill_expect(input logic [LW-1:0] line, input logic [DW-1:0] d [4],
                               input int n, input string rq);
    refill_valid = 1'b1; refill_line = line;
    @(posedge clk); #1 refill_valid = 1'b0;
    wait_wakes(line, d, n, rq);
  endtask

  task automatic refill_only(input logic [LW-1:0] line);
    refill_valid = 1'b1; refill_line = line;
    @(posedge clk); #1 refill_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    miss_valid = 0; refill_valid = 0; miss_line = '0; refill_line = '0; miss_dest = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9", "stall in reset", stall, 0);
    chk("R9", "mem_req_valid in reset", mem_req_valid, 0);
    chk("R9", "wake_valid in reset", wake_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "wake_valid after reset", wake_valid, 0);
    chk("R9", "stall after reset", stall, 0);
  endtask

  task automatic t_primary_merge();
    logic [DW-1:0] d [4] = '{5'd3, 5'd7, 5'd9, 5'd0};
    do_miss(26'h0A0, 5'd3, 0, 1, "R1");
    do_miss(26'h0A0, 5'd7, 0, 0, "R2");
    do_miss(26'h0A0, 5'd9, 0, 0, "R2");
    repeat (MEM_LAT) @(negedge clk);
    refill_expect(26'h0A0, d, 3, "R5");
    do_miss(26'h0A0, 5'd4, 0, 1, "R6");
    d = '{5'd4, 5'd0, 5'd0, 5'd0};
    refill_expect(26'h0A0, d, 1, "R6");
  endtask

  task automatic t_slots_full();
    logic [DW-1:0] d [4] = '{5'd1, 5'd2, 5'd3, 5'd4};
    do_miss(26'h0B0, 5'd1, 0, 1, "R1");
    do_miss(26'h0B0, 5'd2, 0, 0, "R2");
    do_miss(26'h0B0, 5'd3, 0, 0, "R2");
    do_miss(26'h0B0, 5'd4, 0, 0, "R2");
    do_miss(26'h0B0, 5'd5, 1, 0, "R4");
    refill_expect(26'h0B0, d, 4, "R4");
  endtask

  task automatic t_all_busy();
    logic [DW-1:0] d [4] = '{5'd0, 5'd0, 5'd0, 5'd0};
    for (int i = 0; i < 8; i++) do_miss(26'h100 + i, DW'(i + 10), 0, 1, "R1");
    do_miss(26'h1FF, 5'd30, 1, 0, "R3");
    d[0] = 5'd13;
    refill_expect(26'h103, d, 1, "R5");
    do_miss(26'h1FF, 5'd30, 0, 1, "R6");
    do_miss(26'h1FE, 5'd31, 1, 0, "R3");
    for (int i = 0; i < 8; i++) begin
      if (i != 3) begin
        d[0] = DW'(i + 10);
        refill_expect(26'h100 + i, d, 1, "R5");
      end
    end
    d[0] = 5'd30;
    refill_expect(26'h1FF, d, 1, "R6");
  endtask

  task automatic t_stray_refill();
    logic [DW-1:0] d [4] = '{5'd6, 5'd8, 5'd0, 5'd0};
    do_miss(26'h0E0, 5'd6, 0, 1, "R1");
    refill_only(26'h0E1);
    for (int i = 0; i < 3; i++) begin
      chk("R7", "wake_valid after stray fill", wake_valid, 0);
      @(negedge clk);
    end
    do_miss(26'h0E0, 5'd8, 0, 0, "R7");
    refill_expect(26'h0E0, d, 2, "R7");
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] d [4] = '{5'd1, 5'd2, 5'd0, 5'd0};
    do_miss(26'h0C0, 5'd1, 0, 1, "R1");
    miss_valid = 1'b1; miss_line = 26'h0C0; miss_dest = 5'd2;
    refill_valid = 1'b1; refill_line = 26'h0C0;
    #1;
    chk("R8", "stall", stall, 0);
    chk("R8", "mem_req_valid", mem_req_valid, 0);
    @(posedge clk); #1 miss_valid = 1'b0; refill_valid = 1'b0;
    wait_wakes(26'h0C0, d, 2, "R8");
  endtask

  task automatic t_order();
    logic [DW-1:0] got_d [7];
    logic [LW-1:0] got_l [7];
    logic [DW-1:0] exp_d [7] = '{5'd10, 5'd11, 5'd12, 5'd13, 5'd1, 5'd2, 5'd5};
    logic [LW-1:0] exp_l [7] = '{26'h0F0, 26'h0F0, 26'h0F0, 26'h0F0,
                                 26'h0C8, 26'h0C8, 26'h0D0};
    int n = 0;
    do_miss(26'h0C8, 5'd1, 0, 1, "R10");
    do_miss(26'h0C8, 5'd2, 0, 0, "R10");
    do_miss(26'h0D0, 5'd5, 0, 1, "R10");
    for (int i = 0; i < 4; i++) do_miss(26'h0F0, DW'(i + 10), 0, (i == 0), "R10");
    fork
      begin
        refill_only(26'h0F0);
        refill_only(26'h0D0);
        refill_only(26'h0C8);
      end
      begin
        for (int c = 0; c < 40 && n < 7; c++) begin
          @(negedge clk);
          if (wake_valid) begin
            got_d[n] = wake_dest; got_l[n] = wake_line; n++;
          end
        end
      end
    join
    chk("R10", "wake count", n, 7);
    for (int i = 0; i < n; i++) begin
      chk("R10", "order dest", got_d[i], exp_d[i]);
      chk("R10", "order line", got_l[i], exp_l[i]);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk);
    t_order();
    t_primary_merge();
    t_slots_full();
    t_all_busy();
    t_stray_refill();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule